// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block keeps an asynchronous page-mode DRAM alive. After reset it holds off for a programmable start-up delay. It then fires a fixed burst of warm-up refresh cycles and only then declares the memory usable. From that point on it spreads refresh cycles evenly over the retention period, one every interval. The 4096-row variant needs 4096 cycles every 64 ms and the 2048-row variant needs 2048 every 32 ms, so both come to one refresh about every 15.6 µs. Every refresh is a CAS-before-RAS cycle, so no row address is needed and the address bus is left alone.

The block sits next to an access sequencer that owns the address and data paths. The sequencer raises a request. It may start a read or write only in a cycle where the grant output is high, and it keeps its busy input high from the cycle after the grant until its own access and precharge are over. A due refresh never cuts into such an access. It waits for busy to drop and then wins over any new request. Refreshes that fall due while the host keeps the memory are counted, up to a configurable limit, and all of them are run once the host lets go. A refresh that falls due while the limit is already reached is lost, and a sticky error output reports it. All times are parameters in clock cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ras_n, cas_n and we_n are 1, and mem_ready, host_grant and backlog_err are 0, even with host_req at 1.
- R2: No strobe moves during the first STARTUP_CYC cycles after reset. Then exactly WARMUP_CNT refresh cycles run back to back. mem_ready rises only after the last of them has finished its precharge, and it stays high until reset.
- R3: In each refresh, cas_n falls exactly CSR_CYC cycles before ras_n falls. cas_n rises exactly CHR_CYC cycles after ras_n falls, and it rises while ras_n is still low.
- R4: we_n is 1 whenever ras_n falls or rises.
- R5: ras_n stays low for exactly RAS_CYC cycles. After ras_n rises, at least RP_CYC cycles pass before cas_n falls again.
- R6: Once mem_ready is high and the host is idle, consecutive refreshes start exactly INTERVAL_CYC cycles apart. Under short host accesses the refresh count never falls behind the elapsed intervals.
- R7: A refresh never begins, that is cas_n never falls, in a cycle that follows a cycle where host_busy was 1.
- R8: While a due refresh is still owed, host_grant stays 0 even with host_req at 1 and host_busy at 0.
- R9: host_grant is 1 in the same cycle that host_req is 1 whenever mem_ready is 1, no refresh is owed or running, and host_busy is 0. host_grant is never 1 while a refresh drives the strobes.
- R10: Up to MAX_OWED refreshes that fall due during a long host access are remembered, and all of them run back to back after host_busy falls. When one more falls due with MAX_OWED already owed, that refresh is dropped, and backlog_err goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access sequencer wants the memory |
| host_busy | input | 1 | Host access or its precharge in progress |
| host_grant | output | 1 | Host may start an access this cycle |
| refresh_active | output | 1 | A refresh cycle owns the strobes |
| mem_ready | output | 1 | Start-up delay and warm-up burst are complete |
| backlog_err | output | 1 | Sticky: a refresh was dropped because the backlog was full |
| ras_n | output | 1 | Row strobe toward the DRAM, active low |
| cas_n | output | 1 | Column strobe toward the DRAM, active low |
| we_n | output | 1 | Write enable toward the DRAM, held high |

## Verification
On every cycle the built-in properties check that CAS leads RAS, that CAS rises while RAS is low, that the RAS low width is exact and the precharge floor is met, that no refresh starts out of a busy host cycle, that no grant is given while a refresh is owed, and that the error flag is sticky. Other behaviours can only be shown by the bench's scenarios. These are the exact start-up length and the warm-up count before ready. They also include the spacing of periodic refreshes, the number of refreshes replayed after a long host hold, and the overflow case where one due refresh is lost. A random mix of short host accesses then tests arbitration fairness against the interval schedule.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        CBR_IDLE,
        CBR_CAS_LEAD,
        CBR_RAS_CAS,
        CBR_RAS_ONLY,
        CBR_PRECHG
    } cbr_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_strobe_t;

    // Strobe levels for each refresh phase; write enable is never asserted.
    function automatic dram_strobe_t strobe_for(cbr_state_e s);
        dram_strobe_t o;
        o = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        unique case (s)
            CBR_CAS_LEAD: o.cas_n = 1'b0;
            CBR_RAS_CAS: begin
                o.cas_n = 1'b0;
                o.ras_n = 1'b0;
            end
            CBR_RAS_ONLY: o.ras_n = 1'b0;
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int STARTUP_CYC  = 50000,
    parameter int INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic boot_done,
    output logic tick
);
    localparam int BOOT_W = $clog2(STARTUP_CYC + 1);
    localparam int INT_W  = $clog2(INTERVAL_CYC + 1);

    logic [BOOT_W-1:0] boot_cnt;
    logic [INT_W-1:0]  int_cnt;
    logic              int_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_cnt  <= '0;
            boot_done <= 1'b0;
        end else if (!boot_done) begin
            if (boot_cnt == BOOT_W'(STARTUP_CYC - 1)) boot_done <= 1'b1;
            else                                      boot_cnt  <= boot_cnt + 1'b1;
        end
    end

    assign int_last = (int_cnt == INT_W'(INTERVAL_CYC - 1));
    assign tick     = run && int_last;

    always_ff @(posedge clk) begin
        if (rst || !run)   int_cnt <= '0;
        else if (int_last) int_cnt <= '0;
        else               int_cnt <= int_cnt + 1'b1;
    end

    AST_BOOT_STAYS: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done); // R2

endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int MAX_OWED = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           due,
    input  logic                           take,
    output logic [$clog2(MAX_OWED+1)-1:0]  owed,
    output logic                           overflow
);
    localparam int OW_W = $clog2(MAX_OWED + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed     <= '0;
            overflow <= 1'b0;
        end else begin
            unique case ({due, take})
                2'b10: begin
                    if (owed == OW_W'(MAX_OWED)) overflow <= 1'b1;
                    else                         owed     <= owed + 1'b1;
                end
                2'b01:   owed <= owed - 1'b1;
                default: ;
            endcase
        end
    end

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R10
    AST_TAKE_ONLY_OWED: assert property (@(posedge clk) disable iff (rst)
        take |-> owed != '0); // R10

endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int CSR_CYC = 2,
    parameter int CHR_CYC = 3,
    parameter int RAS_CYC = 13,
    parameter int RP_CYC  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         busy,
    output dram_strobe_t strobe
);
    localparam int PH_W = $clog2(CSR_CYC + RAS_CYC + RP_CYC + 1);

    cbr_state_e      state;
    logic [PH_W-1:0] ph_cnt;
    logic            ph_last;

    function automatic logic [PH_W-1:0] phase_len(cbr_state_e s);
        unique case (s)
            CBR_CAS_LEAD: return PH_W'(CSR_CYC);
            CBR_RAS_CAS:  return PH_W'(CHR_CYC);
            CBR_RAS_ONLY: return PH_W'(RAS_CYC - CHR_CYC);
            CBR_PRECHG:   return PH_W'(RP_CYC);
            default:      return PH_W'(1);
        endcase
    endfunction

    assign ph_last = (ph_cnt == phase_len(state) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CBR_IDLE;
            ph_cnt <= '0;
        end else if (state == CBR_IDLE) begin
            ph_cnt <= '0;
            if (start) state <= CBR_CAS_LEAD;
        end else if (ph_last) begin
            ph_cnt <= '0;
            unique case (state)
                CBR_CAS_LEAD: state <= CBR_RAS_CAS;
                CBR_RAS_CAS:  state <= CBR_RAS_ONLY;
                CBR_RAS_ONLY: state <= CBR_PRECHG;
                default:      state <= CBR_IDLE;
            endcase
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    assign busy   = (state != CBR_IDLE);
    assign strobe = strobe_for(state);

    // Independent width counters watching the strobe pins.
    localparam int CK_W = $clog2(RAS_CYC + RP_CYC + 2);
    logic [CK_W-1:0] low_run, high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= CK_W'(RP_CYC);
        end else if (!strobe.ras_n) begin
            low_run  <= low_run + 1'b1;
            high_run <= '0;
        end else begin
            low_run  <= '0;
            if (high_run < CK_W'(RP_CYC)) high_run <= high_run + 1'b1;
        end
    end

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe.ras_n) |-> !strobe.cas_n && $past(!strobe.cas_n)); // R3
    AST_CAS_RISES_IN_RAS: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.cas_n) |-> !strobe.ras_n); // R3
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.ras_n) |-> low_run == CK_W'(RAS_CYC)); // R5
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe.ras_n) |-> high_run >= CK_W'(RP_CYC)); // R5

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_refresh_pkg::*;
#(
    parameter int STARTUP_CYC  = 50000,
    parameter int WARMUP_CNT   = 8,
    parameter int INTERVAL_CYC = 3900,
    parameter int CSR_CYC      = 2,
    parameter int CHR_CYC      = 3,
    parameter int RAS_CYC      = 13,
    parameter int RP_CYC       = 8,
    parameter int MAX_OWED     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic host_busy,
    output logic host_grant,
    output logic refresh_active,
    output logic mem_ready,
    output logic backlog_err,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int WARM_W = (WARMUP_CNT < 1) ? 1 : $clog2(WARMUP_CNT + 1);
    localparam int OW_W   = $clog2(MAX_OWED + 1);

    logic              boot_done, tick, seq_busy, start, want_ref, grant_q;
    logic [WARM_W-1:0] warm_left;
    logic [OW_W-1:0]   owed;
    dram_strobe_t      strobe;

    refresh_timer #(
        .STARTUP_CYC (STARTUP_CYC),
        .INTERVAL_CYC(INTERVAL_CYC)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .run      (mem_ready),
        .boot_done(boot_done),
        .tick     (tick)
    );

    refresh_backlog #(.MAX_OWED(MAX_OWED)) backlog_i (
        .clk     (clk),
        .rst     (rst),
        .due     (tick),
        .take    (start && mem_ready),
        .owed    (owed),
        .overflow(backlog_err)
    );

    cbr_sequencer #(
        .CSR_CYC(CSR_CYC),
        .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) seq_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (seq_busy),
        .strobe(strobe)
    );

    // Refresh is owed either from the warm-up burst or from the periodic backlog.
    assign want_ref = boot_done && (mem_ready ? (owed != '0) : (warm_left != '0));
    // Never start out of a host access, nor in the cycle after a grant.
    assign start    = want_ref && !seq_busy && !host_busy && !grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_left <= WARM_W'(WARMUP_CNT);
            mem_ready <= 1'b0;
            grant_q   <= 1'b0;
        end else begin
            grant_q <= host_grant;
            if (start && !mem_ready) warm_left <= warm_left - 1'b1;
            if (boot_done && warm_left == '0 && !seq_busy) mem_ready <= 1'b1;
        end
    end

    assign host_grant     = host_req && mem_ready && !want_ref && !seq_busy && !host_busy;
    assign refresh_active = seq_busy;
    assign ras_n          = strobe.ras_n;
    assign cas_n          = strobe.cas_n;
    assign we_n           = strobe.we_n;

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_active) |-> $past(!host_busy)); // R7
    AST_NO_GRANT_WHEN_OWED: assert property (@(posedge clk) disable iff (rst)
        (mem_ready && owed != '0) |-> !host_grant); // R8
    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        host_grant |-> ras_n && cas_n); // R9
    AST_READY_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ready) |-> $past(!refresh_active) && warm_left == '0); // R2
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready); // R2

endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb_top;
    localparam int STARTUP  = 40;
    localparam int WARM     = 8;
    localparam int INTERVAL = 100;
    localparam int CSR      = 2;
    localparam int CHR      = 3;
    localparam int RASW     = 13;
    localparam int RP       = 8;
    localparam int MAXOWED  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0;
    logic host_busy = 1'b0;
    logic host_grant, refresh_active, mem_ready, backlog_err, ras_n, cas_n, we_n;

    dram_refresh_ctrl #(
        .STARTUP_CYC(STARTUP), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTERVAL),
        .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP), .MAX_OWED(MAXOWED)
    ) dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_busy(host_busy),
        .host_grant(host_grant), .refresh_active(refresh_active), .mem_ready(mem_ready),
        .backlog_err(backlog_err), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int owed_after_hold(input int ticks_in_window, input int limit);
        return (ticks_in_window > limit) ? limit : ticks_in_window;
    endfunction

    // Host busy as sampled by the design at each rising edge.
    logic busy_at_edge = 1'b0;
    always @(posedge clk) busy_at_edge <= host_busy;

    // Pin monitor
    int  cyc = 0, ras_falls = 0, cas_fall_t = 0, ras_fall_t = 0, ras_rise_t = -1000;
    bit  seen_cas = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_rdy = 1'b0;

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            cyc++;
            if (p_cas && !cas_n) begin
                if (!seen_cas) chk(cyc >= STARTUP && cyc <= STARTUP + 2, "R2 first refresh", cyc, STARTUP + 1);
                seen_cas = 1;
                chk(!busy_at_edge, "R7 start out of busy", busy_at_edge, 0);
                chk(cyc - ras_rise_t >= RP, "R5 precharge", cyc - ras_rise_t, RP);
                cas_fall_t = cyc;
            end
            if (p_ras && !ras_n) begin
                chk(cyc - cas_fall_t == CSR, "R3 cas lead", cyc - cas_fall_t, CSR);
                chk(we_n == 1'b1, "R4 we at ras fall", we_n, 1);
                ras_falls++;
                ras_fall_t = cyc;
            end
            if (!p_cas && cas_n) chk(!ras_n && cyc - ras_fall_t == CHR, "R3 cas hold", cyc - ras_fall_t, CHR);
            if (!p_ras && ras_n) begin
                chk(cyc - ras_fall_t == RASW, "R5 ras width", cyc - ras_fall_t, RASW);
                chk(we_n == 1'b1, "R4 we at ras rise", we_n, 1);
                ras_rise_t = cyc;
            end
            if (!p_rdy && mem_ready) begin
                chk(ras_falls == WARM, "R2 warm-up count", ras_falls, WARM);
                chk(cyc - ras_rise_t >= RP, "R2 ready after precharge", cyc - ras_rise_t, RP);
            end
            if (p_rdy && !mem_ready) chk(0, "R2 ready dropped", 0, 1);
            if (host_grant) chk(mem_ready && ras_n && cas_n && !refresh_active, "R9 grant exclusive", 0, 1);
            p_ras = ras_n; p_cas = cas_n; p_rdy = mem_ready;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    // Get a grant with req raised at a negedge; returns at negedge+1 with busy raised.
    task automatic acquire(input string req);
        int w = 0;
        host_req = 1'b1;
        #1;
        while (!host_grant && w < 400) begin
            @(negedge clk); #1; w++;
        end
        chk(host_grant, req, host_grant, 1);
        host_busy = 1'b1;
        host_req  = 1'b0;
    endtask

    task automatic after_refresh();
        @(posedge ras_n);
        repeat (RP + 2) @(negedge clk);
    endtask

    // Hold the memory HOLD cycles, starting just after a periodic refresh, then replay.
    task automatic long_hold(input int hold, input int ticks);
        int n0, w, exp_n;
        after_refresh();
        acquire("R9 grant before hold");
        repeat (hold) @(negedge clk);
        host_busy = 1'b0;
        host_req  = 1'b1;
        #1;
        chk(!host_grant, "R8 grant while owed", host_grant, 0);
        n0 = ras_falls;
        w = 0;
        while (!host_grant && w < 400) begin
            @(negedge clk); #1; w++;
        end
        exp_n = owed_after_hold(ticks, MAXOWED);
        chk(ras_falls - n0 == exp_n, "R10 replayed refreshes", ras_falls - n0, exp_n);
        host_busy = 1'b1; host_req = 1'b0;
        @(negedge clk);
        host_busy = 1'b0;
    endtask

    initial begin
        int n0, t1, c0;
        void'($urandom(32'h5eed_0417));
        host_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        chk(!mem_ready, "R1 ready in reset", mem_ready, 0);
        chk(!host_grant, "R1 grant in reset", host_grant, 0);
        chk(!backlog_err, "R1 err in reset", backlog_err, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(ras_n && cas_n && !host_grant && !mem_ready, "R1 after reset", host_grant, 0);
        host_req = 1'b0;

        wait (mem_ready);
        chk(ras_falls == WARM, "R2 burst before ready", ras_falls, WARM);

        // R6 periodic spacing with idle host
        for (int k = 0; k < 2; k++) begin
            n0 = ras_falls;
            wait (ras_falls == n0 + 1); t1 = ras_fall_t;
            wait (ras_falls == n0 + 2);
            chk(ras_fall_t - t1 == INTERVAL, "R6 spacing", ras_fall_t - t1, INTERVAL);
        end

        // R9 immediate grant when idle
        after_refresh();
        @(negedge clk);
        host_req = 1'b1;
        #1;
        chk(host_grant, "R9 same-cycle grant", host_grant, 1);
        host_busy = 1'b1; host_req = 1'b0;
        repeat (5) @(negedge clk);
        host_busy = 1'b0;

        // R7/R8/R10: hold across two due points
        long_hold(2 * INTERVAL - 20, 2);
        chk(!backlog_err, "R10 no error within limit", backlog_err, 0);

        // Random short accesses
        c0 = cyc; n0 = ras_falls;
        for (int k = 0; k < 150; k++) begin
            repeat ($urandom_range(0, 15)) @(negedge clk);
            acquire("R9 random grant");
            repeat ($urandom_range(1, 12)) @(negedge clk);
            host_busy = 1'b0;
        end
        chk(ras_falls - n0 >= (cyc - c0) / INTERVAL - 1, "R6 keeps pace", ras_falls - n0, (cyc - c0) / INTERVAL - 1);
        chk(!backlog_err, "R10 no error under short access", backlog_err, 0);

        // Overflow: four due points with a limit of three
        long_hold(4 * INTERVAL - 20, 4);
        chk(backlog_err, "R10 overflow flag", backlog_err, 1);
        repeat (2 * INTERVAL) @(negedge clk);
        chk(backlog_err, "R10 flag sticky", backlog_err, 1);

        summary();
        $finish;
    end
endmodule